// File: doc/BRIEF.md
# Interval Timer with Byte-Pair Loading

This block is a two-counter programmable interval timer. The counters are slot 0 and slot 2, and both decrement on a shared count-enable strobe (`tick`). In the target system that strobe arrives at 1,193,180 Hz, so one expiry period equals the programmed count times about 838 ns.

Software first writes a control byte to choose a counter and record its mode. It then writes a 16-bit reload value to a data port as two bytes: the low byte first, then the high byte. The counter starts when the high byte arrives. It fires once every `count` strobes and reloads itself after each expiry.

Each expiry gives a one-cycle interrupt pulse and sets a status byte. The status byte of counter 2 can be read back. Two kinds of control byte are flagged as errors: an access mode other than low-then-high, and the read-back command.

Top module: `ivt_timer`

Port map: `wr_addr`/`rd_addr` 0 = counter 0 data, 1 = counter 1 (ignored), 2 = counter 2 data, 3 = control.

The control byte has three fields:
- bits 7:6 select the target (0 = counter 0, 1 = counter 1, 2 = counter 2, 3 = read-back command);
- bits 5:4 give the access mode, and only 2'b11 (low then high) is valid;
- bits 3:1 give the counting mode.

State machines:
- Byte sequencer: states `SEQ_LOW` and `SEQ_HIGH`.
  - `SEQ_LOW -> SEQ_HIGH` on any data write, which captures the low byte.
  - `SEQ_HIGH -> SEQ_LOW` on any data write, which issues the load.
- Each counter: states `CNT_IDLE` and `CNT_RUN`.
  - `CNT_IDLE -> CNT_RUN` on a load.
  - `CNT_RUN` holds; a load there restarts the count.

## Requirements
- R1: After reset both counters are idle, `irq0`, `irq2`, `err_access` and `err_readback` are 0, `mode0` and `mode2` are 0, `rd_data` is 0 for every `rd_addr`, and the sequencer expects a low byte.
- R2: A control write (address 3) whose bits 5:4 are 2'b11 and whose bits 7:6 are 0 or 2 stores bits 3:1 into `mode0` or `mode2` respectively. The new mode is visible after the write's clock edge.
- R3: A control write whose bits 5:4 are not 2'b11 raises `err_access` for exactly the one cycle after the write. That write changes no mode and raises no `err_readback`, whatever its bits 7:6 are.
- R4: A control write with bits 5:4 = 2'b11 and bits 7:6 = 2'b11 raises `err_readback` for one cycle and changes nothing else. Bits 7:6 = 2'b01 with a valid access mode is ignored and raises no error.
- R5: Data writes to address 0 or 2 share one low/high sequencer. The first stores the low byte; the second starts the counter addressed by that second write with count = {second byte, first byte}. Control writes and address-1 writes do not disturb the pending low byte.
- R6: A started counter pulses its interrupt in the cycle after the N-th `tick` edge following the load, and every N ticks after that. A count of 0 means 65536.
- R7: Each expiry of counter 2 sets its status to 8'h20. A load of counter 2 clears its status to 0. `rd_data` shows counter 2's status when `rd_addr` = 2 and is 0 for other addresses.
- R8: A load on a running counter restarts it with the new count. A `tick` in the same cycle as the load is not counted.
- R9: Each interrupt pulse lasts exactly one cycle per expiry, and the two counters expire independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable strobe, one per timer-input period |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write port select |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 2 | Read port select |
| rd_data | output | 8 | Read byte (counter 2 status at address 2) |
| irq0 | output | 1 | Counter 0 expiry pulse |
| irq2 | output | 1 | Counter 2 expiry pulse |
| mode0 | output | 3 | Stored mode of counter 0 |
| mode2 | output | 3 | Stored mode of counter 2 |
| err_access | output | 1 | Unsupported access-mode pulse |
| err_readback | output | 1 | Read-back command pulse |

## Verification
- Modes and error pulses are registered, so they are due one rising edge after the write.
- A load takes effect at the edge that accepts the high byte.
- An interrupt is due right after the N-th ticking edge that follows that load.
- `rd_data` is combinational from the status register, which changes at the expiry edge.
- Each bench step drives inputs on a falling edge and lets one rising edge pass. A cycle-level reference model advances with that edge, and the outputs are compared at the next falling edge, so every result is sampled exactly one edge after its cause.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [0:0] {
        SEQ_LOW  = 1'b0,
        SEQ_HIGH = 1'b1
    } seq_state_t;

    typedef enum logic [0:0] {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_t;

    typedef struct packed {
        logic       bad_access;
        logic       readback;
        logic       sel_c0;
        logic       sel_c2;
        logic [2:0] mode;
    } ctl_dec_t;

    localparam logic [1:0] PORT_C0  = 2'd0;
    localparam logic [1:0] PORT_C2  = 2'd2;
    localparam logic [1:0] PORT_CTL = 2'd3;

    localparam logic [1:0] SEL_C0   = 2'd0;
    localparam logic [1:0] SEL_C2   = 2'd2;
    localparam logic [1:0] SEL_RB   = 2'd3;
    localparam logic [1:0] ACC_LOHI = 2'b11;

    localparam logic [7:0] STAT_EXPIRED = 8'h20;

    function automatic logic [1:0] slot_port(input int slot);
        return (slot == 0) ? PORT_C0 : PORT_C2;
    endfunction

endpackage

// File: rtl/ivt_ctl_decode.sv
module ivt_ctl_decode
    import ivt_pkg::*;
(
    input  logic [7:1] ctl_bits,
    output ctl_dec_t   dec
);
    logic [1:0] sel;
    logic [1:0] acc;

    always_comb begin
        sel            = ctl_bits[7:6];
        acc            = ctl_bits[5:4];
        dec.mode       = ctl_bits[3:1];
        // access check wins over the target decode
        dec.bad_access = (acc != ACC_LOHI);
        dec.readback   = !dec.bad_access && (sel == SEL_RB);
        dec.sel_c0     = !dec.bad_access && (sel == SEL_C0);
        dec.sel_c2     = !dec.bad_access && (sel == SEL_C2);
    end
endmodule

// File: rtl/ivt_byte_seq.sv
module ivt_byte_seq
    import ivt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_wr,
    input  logic [BYTE_W-1:0]   byte_in,
    output logic                load_go,
    output logic [2*BYTE_W-1:0] load_value,
    output logic                pending
);
    seq_state_t          state, state_nx;
    logic [BYTE_W-1:0]   low_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_LOW;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_LOW:  if (byte_wr) state_nx = SEQ_HIGH;
            SEQ_HIGH: if (byte_wr) state_nx = SEQ_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                           low_q <= '0;
        else if (byte_wr && state == SEQ_LOW) low_q <= byte_in;
    end

    always_comb begin
        load_go    = 1'b0;
        pending    = 1'b0;
        load_value = {byte_in, low_q};
        unique case (state)
            SEQ_LOW:  ;
            SEQ_HIGH: begin
                pending = 1'b1;
                load_go = byte_wr;
            end
        endcase
    end

    // R5: a load always returns the sequencer to expecting a low byte
    a_r5_load_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> !pending);
    // R5: a first byte always leaves a pending low byte
    a_r5_low_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && !pending) |=> pending);
endmodule

// File: rtl/ivt_down_counter.sv
module ivt_down_counter
    import ivt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_go,
    input  logic [CNT_W-1:0]  load_value,
    output logic              irq,
    output logic [STAT_W-1:0] status
);
    localparam int             RW       = CNT_W + 1;
    localparam logic [RW-1:0]  CNT_ONE  = RW'(1);
    localparam logic [RW-1:0]  CNT_FULL = CNT_ONE << CNT_W;

    cnt_state_t     state, state_nx;
    logic [RW-1:0]  cnt;
    logic [RW-1:0]  rel;
    logic [RW-1:0]  eff_load;

    assign eff_load = (load_value == '0) ? CNT_FULL : {1'b0, load_value};

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CNT_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CNT_IDLE: if (load_go) state_nx = CNT_RUN;
            CNT_RUN:  state_nx = CNT_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            rel    <= '0;
            irq    <= 1'b0;
            status <= '0;
        end else begin
            irq <= 1'b0;
            if (load_go) begin
                rel    <= eff_load;
                cnt    <= eff_load;
                status <= '0;
            end else if (state == CNT_RUN && tick) begin
                if (cnt == CNT_ONE) begin
                    cnt    <= rel;
                    irq    <= 1'b1;
                    status <= STAT_W'(STAT_EXPIRED);
                end else begin
                    cnt <= cnt - CNT_ONE;
                end
            end
        end
    end

    // R6: a running count stays within 1..reload
    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CNT_RUN) |-> (cnt != '0 && cnt <= rel));
    // R6: the last tick reloads and fires
    a_r6_reload_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CNT_RUN && tick && !load_go && cnt == CNT_ONE) |=> (irq && cnt == rel));
    // R7: every pulse comes with the expired status
    a_r7_status_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status == STAT_W'(STAT_EXPIRED)));
    // R8: a load restarts at the full count with no pulse
    a_r8_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> (state == CNT_RUN && cnt == rel && !irq && status == '0));
    // R9: no pulse from an idle counter
    a_r9_irq_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(state == CNT_RUN));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq0,
    output logic              irq2,
    output logic [2:0]        mode0,
    output logic [2:0]        mode2,
    output logic              err_access,
    output logic              err_readback
);
    localparam int CNT_W     = 2 * BYTE_W;
    localparam int NUM_SLOTS = 2;

    logic               ctl_wr;
    logic               byte_wr;
    ctl_dec_t           dec;
    logic               seq_load;
    logic [CNT_W-1:0]   seq_value;
    logic               seq_pending;
    logic [NUM_SLOTS-1:0] slot_irq;
    logic [BYTE_W-1:0]  slot_stat [NUM_SLOTS];
    logic [BYTE_W-1:0]  rd_part   [NUM_SLOTS];

    assign ctl_wr  = wr_en && (wr_addr == PORT_CTL);
    assign byte_wr = wr_en && (wr_addr == PORT_C0 || wr_addr == PORT_C2);

    ivt_ctl_decode u_dec (
        .ctl_bits (wr_data[7:1]),
        .dec      (dec)
    );

    ivt_byte_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_wr    (byte_wr),
        .byte_in    (wr_data),
        .load_go    (seq_load),
        .load_value (seq_value),
        .pending    (seq_pending)
    );

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            localparam logic [1:0] MY_PORT  = slot_port(g);
            localparam bit         READABLE = (g == NUM_SLOTS - 1);
            logic slot_load;
            assign slot_load = seq_load && (wr_addr == MY_PORT);

            ivt_down_counter #(.CNT_W(CNT_W), .STAT_W(BYTE_W)) u_cnt (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick       (tick),
                .load_go    (slot_load),
                .load_value (seq_value),
                .irq        (slot_irq[g]),
                .status     (slot_stat[g])
            );

            assign rd_part[g] = (READABLE && rd_addr == MY_PORT) ? slot_stat[g] : '0;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SLOTS; i++) rd_data = rd_data | rd_part[i];
    end

    assign irq0 = slot_irq[0];
    assign irq2 = slot_irq[NUM_SLOTS-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode0        <= '0;
            mode2        <= '0;
            err_access   <= 1'b0;
            err_readback <= 1'b0;
        end else begin
            err_access   <= ctl_wr && dec.bad_access;
            err_readback <= ctl_wr && dec.readback;
            if (ctl_wr && dec.sel_c0) mode0 <= dec.mode;
            if (ctl_wr && dec.sel_c2) mode2 <= dec.mode;
        end
    end

    // R3: the two error kinds never coincide
    a_r3_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_access && err_readback));
    // R3: a rejected access mode leaves both modes alone
    a_r3_bad_keeps_modes: assert property (@(posedge clk) disable iff (!rst_n)
        err_access |-> ($stable(mode0) && $stable(mode2)));
    // R4: a read-back command leaves both modes alone
    a_r4_rb_keeps_modes: assert property (@(posedge clk) disable iff (!rst_n)
        err_readback |-> ($stable(mode0) && $stable(mode2)));
    // R2: modes change only through control writes
    a_r2_mode_only_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> ($stable(mode0) && $stable(mode2)));
    // R5: control writes keep the pending low byte state
    a_r5_ctl_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !byte_wr) |=> $stable(seq_pending));
endmodule

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic       irq0, irq2;
    logic [2:0] mode0, mode2;
    logic       err_access, err_readback;

    int nchk = 0;
    int nerr = 0;

    // reference model state
    bit  m_high;
    int  m_low;
    bit  m_run [2];
    int  m_cnt [2];
    int  m_rel [2];
    bit  e_irq [2];
    int  m_stat2;
    int  m_mode [2];
    bit  e_erra, e_errr;

    always #10 clk = ~clk;

    ivt_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq0(irq0),
        .irq2(irq2), .mode0(mode0), .mode2(mode2), .err_access(err_access),
        .err_readback(err_readback)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_high = 0; m_low = 0; m_stat2 = 0; e_erra = 0; e_errr = 0;
        for (int i = 0; i < 2; i++) begin
            m_run[i] = 0; m_cnt[i] = 0; m_rel[i] = 0; e_irq[i] = 0; m_mode[i] = 0;
        end
    endfunction

    function automatic void model_edge(input bit w, input int a, input int d, input bit t);
        bit ctl = w && a == 3;
        bit dat = w && (a == 0 || a == 2);
        int ld  = -1;
        int val = 0;
        int acc = (d >> 4) & 3;
        int sel = (d >> 6) & 3;
        e_erra = ctl && acc != 3;
        e_errr = ctl && acc == 3 && sel == 3;
        if (ctl && acc == 3 && sel == 0) m_mode[0] = (d >> 1) & 7;
        if (ctl && acc == 3 && sel == 2) m_mode[1] = (d >> 1) & 7;
        if (dat) begin
            if (!m_high) begin m_low = d; m_high = 1; end
            else begin
                m_high = 0;
                ld  = (a == 0) ? 0 : 1;
                val = (d << 8) | m_low;
            end
        end
        for (int i = 0; i < 2; i++) begin
            e_irq[i] = 0;
            if (ld == i) begin
                m_run[i] = 1;
                m_rel[i] = (val == 0) ? 65536 : val;
                m_cnt[i] = m_rel[i];
                if (i == 1) m_stat2 = 0;
            end else if (m_run[i] && t) begin
                if (m_cnt[i] == 1) begin
                    m_cnt[i] = m_rel[i];
                    e_irq[i] = 1;
                    if (i == 1) m_stat2 = 'h20;
                end else m_cnt[i] = m_cnt[i] - 1;
            end
        end
    endfunction

    task automatic compare_all();
        chk("R6 R8 R9 irq0", irq0, e_irq[0]);
        chk("R5 R6 R8 R9 irq2", irq2, e_irq[1]);
        chk("R3 err_access", err_access, e_erra);
        chk("R4 err_readback", err_readback, e_errr);
        chk("R2 mode0", mode0, m_mode[0]);
        chk("R2 mode2", mode2, m_mode[1]);
        chk("R7 rd_data", rd_data, (rd_addr == 2) ? m_stat2 : 0);
    endtask

    task automatic step(input bit w, input logic [1:0] a, input logic [7:0] d,
                        input bit t, input logic [1:0] ra);
        wr_en = w; wr_addr = a; wr_data = d; tick = t; rd_addr = ra;
        @(posedge clk);
        model_edge(w, a, d, t);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input bit t);
        step(0, 2'd0, 8'h00, t, 2'd2);
    endtask

    // ticks until the chosen interrupt is seen
    task automatic meas(input int slot, input int maxn, output int n);
        n = 0;
        do begin
            idle(1);
            n++;
        end while (!(slot == 0 ? irq0 : irq2) && n < maxn);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        int n;
        void'($urandom(32'd5150));
        rst_n = 0; tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 2'd2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
        // R1 reset state
        chk("R1 irq0", irq0, 0);
        chk("R1 irq2", irq2, 0);
        chk("R1 err_access", err_access, 0);
        chk("R1 err_readback", err_readback, 0);
        chk("R1 modes", {mode0, mode2}, 0);
        chk("R1 rd_data", rd_data, 0);
        idle(1);
        chk("R1 idle counters silent", {irq0, irq2}, 0);

        // R2 mode writes
        step(1, 2'd3, 8'h36, 0, 2'd2);
        chk("R2 mode0 set", mode0, 3);
        step(1, 2'd3, 8'hB4, 0, 2'd2);
        chk("R2 mode2 set", mode2, 2);
        // R3 bad access
        step(1, 2'd3, 8'h1E, 0, 2'd2);
        chk("R3 err_access pulse", err_access, 1);
        chk("R3 mode0 kept", mode0, 3);
        idle(0);
        chk("R3 err_access one cycle", err_access, 0);
        // R4 read-back, ordering, counter-1 select
        step(1, 2'd3, 8'hF0, 0, 2'd2);
        chk("R4 err_readback pulse", err_readback, 1);
        step(1, 2'd3, 8'hC0, 0, 2'd2);
        chk("R4 bad access wins", {err_access, err_readback}, 2'b10);
        step(1, 2'd3, 8'h7A, 0, 2'd2);
        chk("R4 counter1 select ignored", {err_access, err_readback, mode0, mode2}, {2'b00, 3'd3, 3'd2});

        // R5 shared sequencer: low via port 0, ctl and port-1 writes between, high via port 2
        step(1, 2'd0, 8'h05, 0, 2'd2);
        step(1, 2'd3, 8'h34, 0, 2'd2);
        step(1, 2'd1, 8'h77, 0, 2'd2);
        step(1, 2'd2, 8'h00, 0, 2'd2);
        meas(1, 100, n);
        chk("R5 counter2 period from shared bytes", n, 5);
        chk("R5 counter0 not started", irq0, 0);
        chk("R7 status after expiry", rd_data, 8'h20);
        meas(1, 100, n);
        chk("R6 reload period", n, 5);
        step(0, 2'd0, 8'h00, 0, 2'd0);
        chk("R7 address 0 reads zero", rd_data, 0);

        // R8 reprogram running counter 2, tick during load ignored
        step(1, 2'd2, 8'h0A, 0, 2'd2);
        step(1, 2'd2, 8'h00, 0, 2'd2);
        idle(1); idle(1); idle(1);
        step(1, 2'd2, 8'h04, 1, 2'd2);
        step(1, 2'd2, 8'h00, 1, 2'd2);
        chk("R7 status cleared by load", rd_data, 0);
        meas(1, 100, n);
        chk("R8 restart with new count", n, 4);

        // R9 both counters period 3, aligned
        step(1, 2'd0, 8'h03, 0, 2'd2);
        step(1, 2'd0, 8'h00, 0, 2'd2);
        step(1, 2'd2, 8'h03, 0, 2'd2);
        step(1, 2'd2, 8'h00, 0, 2'd2);
        idle(1); idle(1); idle(1);
        chk("R9 both pulse", {irq0, irq2}, 2'b11);
        idle(1);
        chk("R9 pulse one cycle", {irq0, irq2}, 2'b00);

        // R6 count 0 means 65536
        step(1, 2'd0, 8'h00, 0, 2'd2);
        step(1, 2'd0, 8'h00, 0, 2'd2);
        meas(0, 70000, n);
        chk("R6 zero count is 65536", n, 65536);

        // random mix
        for (int k = 0; k < 4000; k++) begin
            bit         w = ($urandom % 10) < 4;
            logic [1:0] a = 2'($urandom % 4);
            logic [7:0] d;
            if (a == 2'd3) begin
                d = 8'($urandom);
                if (($urandom % 10) < 7) d[5:4] = 2'b11;
            end else begin
                d = (($urandom % 3) == 0) ? 8'($urandom % 4) : 8'h00;
                if (d == 0 && ($urandom % 2) == 0) d = 8'd2;
            end
            step(w, a, d, 1'($urandom % 2), 2'($urandom % 4));
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule